// File: doc/BRIEF.md
# Receive Xon/Xoff Character Detector

This block sits between a serial receiver and its receive FIFO and watches every received character. When a character, or a pair of back-to-back characters, equals the programmed "stop" code, it tells the local transmitter to pause. The pause takes effect only between frames, so a character that is already on the wire is never cut. When the "go" code arrives it releases the transmitter. Characters used for flow control are kept out of the FIFO. All other characters are passed to the FIFO write port in arrival order.

Comparison covers only the active word length of 5 to 8 bits. An any-character resume mode lets any clean received character release a pause. A separate marker mode compares every character with the second stop code, raises a detection flag and an interrupt on a hit, and still stores the character. The four code registers and a control register are written through a small write port, and all of them reset to zero.

In pair mode, the first character of a possible sequence is held back for one character time. If the next character does not complete the sequence, the held character is released to the FIFO, still in its original order.

Top module: `rx_flow_detect`

## Requirements
- R1: After reset, all outputs are low, the four code registers and the control register are zero, and any-character resume is off. Enabling flow control alone therefore makes a received 0x00 act as a stop code.
- R2: In single mode with flow enabled, a clean character equal to the stop-1 code (address 2) under the word-length mask sets the suspend state and the detection flag, and is not written to the FIFO.
- R3: A clean character equal to the go-1 code (address 0) clears the suspend and the detection flag, and is not written. If a character matches both codes, the stop match wins.
- R4: `tx_hold_o` rises only on a cycle where `tx_busy_i` was low on the previous clock. It appears two clocks after the stop character's strobe when the transmitter is idle. It falls two clocks after the go character's strobe.
- R5: With pair mode (control bit 1) set, stop-1 followed by stop-2 (address 3) suspends, and go-1 followed by go-2 (address 1) resumes. Neither character of a completed pair is written.
- R6: In pair mode, a character that does not complete a held sequence makes the held character be written first. The breaking character is then checked again as a new first character. If it is not one, it is written on the following clock, so arrival order is kept.
- R7: Word-length field control[6:5]: 00 compares bits 4:0, 01 compares bits 5:0, 10 compares bits 6:0, 11 compares all 8 bits. Register bit 0 is compared with received bit 0.
- R8: With any-character resume (control bit 2) set, any clean received character clears a suspend. A character that is not a flow code is also written to the FIFO.
- R9: A character marked with `rx_err_i` never matches and never resumes. It is always written to the FIFO.
- R10: With marker mode (control bit 3) set, a clean character equal to stop-2 sets the detection flag. Every character is written and the suspend state is cleared.
- R11: `irq_o` equals the detection flag gated by control bit 4. A pulse on `det_clr_i` clears the flag.
- R12: With flow control (control bit 0) off and marker mode off, every character is written, the flag is not set, and any suspend is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register select: 0 go-1, 1 go-2, 2 stop-1, 3 stop-2, 4 control |
| cfg_wdata_i | input | 8 | Configuration write data |
| rx_valid_i | input | 1 | One-clock strobe for a received character |
| rx_data_i | input | 8 | Received character, bit 0 received first |
| rx_err_i | input | 1 | Framing or parity error on this character |
| tx_busy_i | input | 1 | Transmitter is shifting a frame |
| det_clr_i | input | 1 | Clears the detection flag |
| fifo_we_o | output | 1 | Write strobe to the receive FIFO |
| fifo_data_o | output | 8 | Character to write |
| tx_hold_o | output | 1 | Transmitter must not start a new frame |
| det_flag_o | output | 1 | Stop or marker detection flag |
| irq_o | output | 1 | Interrupt request |

## Verification
In one clock, a broken pair sequence both releases the held first character to the FIFO and captures the breaking character as a new held first character. The bench provokes this with go-1 followed by stop-1, and then stop-2. It judges the result by the single release seen by the scoreboard and by the suspend that follows. A second collision in one clock is a resume under any-character mode together with the storing of that same character. The bench checks it through the FIFO scoreboard and the fall of `tx_hold_o`.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;

   // register select codes on the configuration port
   localparam int unsigned RA_GO1   = 0;
   localparam int unsigned RA_GO2   = 1;
   localparam int unsigned RA_STOP1 = 2;
   localparam int unsigned RA_STOP2 = 3;
   localparam int unsigned RA_CTRL  = 4;

   // control register bit positions
   localparam int unsigned CB_FLOW  = 0;
   localparam int unsigned CB_PAIR  = 1;
   localparam int unsigned CB_ANY   = 2;
   localparam int unsigned CB_MARK  = 3;
   localparam int unsigned CB_IRQ   = 4;
   localparam int unsigned CB_WLEN  = 5;

   // index of each code in the comparator bank
   localparam int unsigned CI_GO1   = 0;
   localparam int unsigned CI_GO2   = 1;
   localparam int unsigned CI_STOP1 = 2;
   localparam int unsigned CI_STOP2 = 3;
   localparam int unsigned N_CODES  = 4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_STOP = 2'd1,
      SQ_GO   = 2'd2
   } seq_st_e;

endpackage

// File: rtl/rx_flow_cfg.sv
module rx_flow_cfg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned WLEN_W = 2
) (
   input  logic                                      clk_i,
   input  logic                                      rst_ni,
   input  logic                                      we_i,
   input  logic [ADDR_W-1:0]                         addr_i,
   input  logic [DATA_W-1:0]                         wdata_i,
   output logic [rx_flow_pkg::N_CODES-1:0][DATA_W-1:0] codes_o,
   output logic                                      flow_en_o,
   output logic                                      pair_o,
   output logic                                      any_o,
   output logic                                      mark_o,
   output logic                                      irq_en_o,
   output logic [WLEN_W-1:0]                         wlen_o
);
   import rx_flow_pkg::*;

   localparam int unsigned CTRL_W = CB_WLEN + WLEN_W;

   initial begin
      if (CTRL_W > DATA_W) $error("control field does not fit the data width");
   end

   logic [CTRL_W-1:0] ctrl_q;

   for (genvar g = 0; g < N_CODES; g++) begin : g_code
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                              codes_o[g] <= '0;
         else if (we_i && int'(addr_i) == g)       codes_o[g] <= wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ctrl_q <= '0;
      else if (we_i && int'(addr_i) == RA_CTRL)     ctrl_q <= wdata_i[CTRL_W-1:0];
   end

   assign flow_en_o = ctrl_q[CB_FLOW];
   assign pair_o    = ctrl_q[CB_PAIR];
   assign any_o     = ctrl_q[CB_ANY];
   assign mark_o    = ctrl_q[CB_MARK];
   assign irq_en_o  = ctrl_q[CB_IRQ];
   assign wlen_o    = ctrl_q[CB_WLEN +: WLEN_W];

endmodule

// File: rtl/rx_flow_match.sv
module rx_flow_match #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WLEN_W   = 2,
   parameter int unsigned MIN_BITS = 5
) (
   input  logic                                        clk_i,
   input  logic                                        rst_ni,
   input  logic [DATA_W-1:0]                           data_i,
   input  logic [WLEN_W-1:0]                           wlen_i,
   input  logic [rx_flow_pkg::N_CODES-1:0][DATA_W-1:0] codes_i,
   output logic [rx_flow_pkg::N_CODES-1:0]             hit_o
);
   import rx_flow_pkg::*;

   logic [DATA_W-1:0] mask;

   // one enable per data bit: bit i is compared when it lies inside the word
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (int'(wlen_i) + int'(MIN_BITS)) > i;
   end

   for (genvar c = 0; c < N_CODES; c++) begin : g_cmp
      assign hit_o[c] = ((data_i ^ codes_i[c]) & mask) == '0;
   end

   // full word length must compare every bit
   p_full_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wlen_i == {WLEN_W{1'b1}} && hit_o[CI_GO1]) |-> (data_i == codes_i[CI_GO1]));

endmodule

// File: rtl/rx_flow_seq.sv
module rx_flow_seq #(
   parameter int unsigned DATA_W = 8
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             rx_valid_i,
   input  logic [DATA_W-1:0]                rx_data_i,
   input  logic                             rx_err_i,
   input  logic [rx_flow_pkg::N_CODES-1:0]  hit_i,
   input  logic                             active_i,
   input  logic                             pair_i,
   output logic                             stop_hit_o,
   output logic                             go_hit_o,
   output logic                             fifo_we_o,
   output logic [DATA_W-1:0]                fifo_data_o
);
   import rx_flow_pkg::*;

   seq_st_e           st_q, st_d;
   logic [DATA_W-1:0] held_q, held_d;
   logic              spill_q, spill_d;
   logic [DATA_W-1:0] spill_data_q;
   logic              wr_now;
   logic [DATA_W-1:0] wr_data;
   logic              clean, first_stop, first_go, second_ok;

   assign clean      = rx_valid_i & ~rx_err_i;
   assign first_stop = active_i & clean & hit_i[CI_STOP1];
   assign first_go   = active_i & clean & hit_i[CI_GO1];
   assign second_ok  = active_i & pair_i & clean &
                       ((st_q == SQ_STOP) ? hit_i[CI_STOP2] : hit_i[CI_GO2]);

   always_comb begin
      st_d       = st_q;
      held_d     = held_q;
      spill_d    = 1'b0;
      wr_now     = 1'b0;
      wr_data    = rx_data_i;
      stop_hit_o = 1'b0;
      go_hit_o   = 1'b0;
      if (st_q == SQ_IDLE) begin
         if (pair_i && first_stop) begin
            held_d = rx_data_i;
            st_d   = SQ_STOP;
         end else if (pair_i && first_go) begin
            held_d = rx_data_i;
            st_d   = SQ_GO;
         end else if (!pair_i && first_stop) begin
            stop_hit_o = 1'b1;
         end else if (!pair_i && first_go) begin
            go_hit_o = 1'b1;
         end else if (rx_valid_i) begin
            wr_now = 1'b1;
         end
      end else if (second_ok) begin
         stop_hit_o = (st_q == SQ_STOP);
         go_hit_o   = (st_q == SQ_GO);
         st_d       = SQ_IDLE;
      end else if (rx_valid_i || !active_i || !pair_i) begin
         // sequence broken: release the held character first
         wr_now  = 1'b1;
         wr_data = held_q;
         st_d    = SQ_IDLE;
         if (rx_valid_i) begin
            if (pair_i && first_stop) begin
               held_d = rx_data_i;
               st_d   = SQ_STOP;
            end else if (pair_i && first_go) begin
               held_d = rx_data_i;
               st_d   = SQ_GO;
            end else if (!pair_i && first_stop) begin
               stop_hit_o = 1'b1;
            end else if (!pair_i && first_go) begin
               go_hit_o = 1'b1;
            end else begin
               spill_d = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q         <= SQ_IDLE;
         held_q       <= '0;
         spill_q      <= 1'b0;
         spill_data_q <= '0;
         fifo_we_o    <= 1'b0;
         fifo_data_o  <= '0;
      end else begin
         st_q         <= st_d;
         held_q       <= held_d;
         spill_q      <= spill_d;
         spill_data_q <= rx_data_i;
         fifo_we_o    <= wr_now | spill_q;
         fifo_data_o  <= wr_now ? wr_data : spill_data_q;
      end
   end

   // the spill slot must never meet a fresh write (strobe spacing rule)
   p_spill_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spill_q |-> !wr_now);

   // an errored character never produces a flow event
   p_err_inert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && rx_err_i) |-> (!stop_hit_o && !go_hit_o));

   // a completed pair leaves nothing to store on the next clock
   p_pair_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != SQ_IDLE && second_ok && !spill_q) |=> !fifo_we_o);

endmodule

// File: rtl/rx_flow_txgate.sv
module rx_flow_txgate #(
   parameter bit FRAME_SAFE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stop_hit_i,
   input  logic go_hit_i,
   input  logic mark_hit_i,
   input  logic rx_clean_i,
   input  logic active_i,
   input  logic any_i,
   input  logic irq_en_i,
   input  logic det_clr_i,
   input  logic tx_busy_i,
   output logic tx_hold_o,
   output logic det_flag_o,
   output logic irq_o
);
   logic susp_q, susp_d;
   logic hold_d;
   logic resume_evt, any_evt;

   assign any_evt    = any_i & rx_clean_i & active_i;
   assign resume_evt = susp_q & ~stop_hit_i & (go_hit_i | any_evt);

   always_comb begin
      if (!active_i)        susp_d = 1'b0;
      else if (stop_hit_i)  susp_d = 1'b1;
      else if (resume_evt)  susp_d = 1'b0;
      else                  susp_d = susp_q;
   end

   if (FRAME_SAFE) begin : g_frame_safe
      // a new hold only starts while the transmitter is between frames
      assign hold_d = susp_q & (tx_hold_o | ~tx_busy_i);
   end else begin : g_immediate
      assign hold_d = susp_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         susp_q     <= 1'b0;
         tx_hold_o  <= 1'b0;
         det_flag_o <= 1'b0;
      end else begin
         susp_q     <= susp_d;
         tx_hold_o  <= hold_d;
         det_flag_o <= stop_hit_i | mark_hit_i |
                       (det_flag_o & ~(go_hit_i | resume_evt | det_clr_i));
      end
   end

   assign irq_o = det_flag_o & irq_en_i;

   p_stop_suspends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_hit_i && active_i) |=> susp_q);

   p_go_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_hit_i && !stop_hit_i && !mark_hit_i) |=> (!susp_q && !det_flag_o));

   p_hold_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_hold_o) |-> (!FRAME_SAFE || !$past(tx_busy_i)));

   p_any_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_evt && susp_q && !stop_hit_i) |=> !susp_q);

   p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o |-> det_flag_o) and (!irq_en_i |-> !irq_o));

endmodule

// File: rtl/rx_flow_detect.sv
module rx_flow_detect #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned WLEN_W     = 2,
   parameter int unsigned MIN_BITS   = 5,
   parameter bit          FRAME_SAFE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_err_i,
   input  logic              tx_busy_i,
   input  logic              det_clr_i,
   output logic              fifo_we_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic              tx_hold_o,
   output logic              det_flag_o,
   output logic              irq_o
);
   import rx_flow_pkg::*;

   localparam int unsigned MAX_BITS = MIN_BITS + (1 << WLEN_W) - 1;

   initial begin
      if (MAX_BITS != DATA_W) $error("word-length range must end at DATA_W");
      if ((1 << ADDR_W) <= RA_CTRL) $error("address too narrow for control register");
   end

   logic [N_CODES-1:0][DATA_W-1:0] codes;
   logic [N_CODES-1:0]             hit;
   logic [WLEN_W-1:0]              wlen;
   logic flow_en, pair, any, mark, irq_en;
   logic active, stop_hit, go_hit, mark_hit, rx_clean;

   rx_flow_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WLEN_W(WLEN_W)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cfg_we_i),
      .addr_i    (cfg_addr_i),
      .wdata_i   (cfg_wdata_i),
      .codes_o   (codes),
      .flow_en_o (flow_en),
      .pair_o    (pair),
      .any_o     (any),
      .mark_o    (mark),
      .irq_en_o  (irq_en),
      .wlen_o    (wlen)
   );

   rx_flow_match #(.DATA_W(DATA_W), .WLEN_W(WLEN_W), .MIN_BITS(MIN_BITS)) u_match (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .data_i  (rx_data_i),
      .wlen_i  (wlen),
      .codes_i (codes),
      .hit_o   (hit)
   );

   assign active   = flow_en & ~mark;
   assign rx_clean = rx_valid_i & ~rx_err_i;
   assign mark_hit = mark & rx_clean & hit[CI_STOP2];

   rx_flow_seq #(.DATA_W(DATA_W)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rx_valid_i  (rx_valid_i),
      .rx_data_i   (rx_data_i),
      .rx_err_i    (rx_err_i),
      .hit_i       (hit),
      .active_i    (active),
      .pair_i      (pair),
      .stop_hit_o  (stop_hit),
      .go_hit_o    (go_hit),
      .fifo_we_o   (fifo_we_o),
      .fifo_data_o (fifo_data_o)
   );

   rx_flow_txgate #(.FRAME_SAFE(FRAME_SAFE)) u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stop_hit_i (stop_hit),
      .go_hit_i   (go_hit),
      .mark_hit_i (mark_hit),
      .rx_clean_i (rx_clean),
      .active_i   (active),
      .any_i      (any),
      .irq_en_i   (irq_en),
      .det_clr_i  (det_clr_i),
      .tx_busy_i  (tx_busy_i),
      .tx_hold_o  (tx_hold_o),
      .det_flag_o (det_flag_o),
      .irq_o      (irq_o)
   );

   // marker mode stores every character on the next clock
   p_mark_stores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mark && rx_valid_i) |=> fifo_we_o);

   // with flow off and marker off nothing is consumed
   p_passthru_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flow_en && !mark && rx_valid_i) |=> (fifo_we_o && fifo_data_o == $past(rx_data_i)));

endmodule

// File: tb/rx_flow_detect_test.sv
`timescale 1ns/100ps
module rx_flow_detect_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_err = 1'b0;
   logic       tx_busy = 1'b0;
   logic       det_clr = 1'b0;
   logic       fifo_we;
   logic [7:0] fifo_data;
   logic       tx_hold, det_flag, irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   rx_flow_detect uut (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
      .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err),
      .tx_busy_i(tx_busy), .det_clr_i(det_clr),
      .fifo_we_o(fifo_we), .fifo_data_o(fifo_data),
      .tx_hold_o(tx_hold), .det_flag_o(det_flag), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int addr, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: one character, optional expected FIFO bytes pushed by caller
   task automatic send(input logic [7:0] d, input bit err);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_err = err;
      @(negedge clk);
      rx_valid = 1'b0; rx_err = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_store(input logic [7:0] d);
      exp_q.push_back(d);
   endtask

   task automatic pulse_clr();
      @(negedge clk); det_clr = 1'b1;
      @(negedge clk); det_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_state(input string req, input bit h, input bit f, input bit i);
      check(tx_hold == h, req, "tx_hold", int'(tx_hold), int'(h));
      check(det_flag == f, req, "det_flag", int'(det_flag), int'(f));
      check(irq == i, req, "irq", int'(irq), int'(i));
   endtask

   // monitor: pop and compare every FIFO write
   always @(negedge clk) begin
      if (rst_n && fifo_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6/R9/R12", "unexpected fifo write", int'(fifo_data), 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(fifo_data == e, "R6/R8/R9/R10/R12", "fifo data", int'(fifo_data), int'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_state("R1", 1'b0, 1'b0, 1'b0);
      check(fifo_we == 1'b0, "R1", "fifo_we", int'(fifo_we), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: codes are zero, so 0x00 is a stop code once flow is on
      cfg_write(4, 8'h71);                 // flow, irq, 8-bit
      send(8'h00, 1'b0);
      chk_state("R1", 1'b1, 1'b1, 1'b1);

      cfg_write(0, 8'h11); cfg_write(1, 8'h22);
      cfg_write(2, 8'h13); cfg_write(3, 8'h33);
      // R3: go code resumes
      send(8'h11, 1'b0);
      chk_state("R3", 1'b0, 1'b0, 1'b0);
      expect_store(8'h41);
      send(8'h41, 1'b0);

      // R2 + R4: stop while transmitter busy
      tx_busy = 1'b1;
      send(8'h13, 1'b0);
      chk_state("R4", 1'b0, 1'b1, 1'b1);
      tx_busy = 1'b0;
      repeat (2) @(negedge clk);
      check(tx_hold == 1'b1, "R2", "tx_hold after frame end", int'(tx_hold), 1);
      send(8'h11, 1'b0);
      chk_state("R3", 1'b0, 1'b0, 1'b0);

      // R11: irq gated, flag cleared by pulse
      cfg_write(4, 8'h61);
      send(8'h13, 1'b0);
      chk_state("R11", 1'b1, 1'b1, 1'b0);
      pulse_clr();
      chk_state("R11", 1'b1, 1'b0, 1'b0);
      send(8'h11, 1'b0);
      check(tx_hold == 1'b0, "R3", "tx_hold", int'(tx_hold), 0);

      // R7: 5-bit compare
      cfg_write(4, 8'h11);
      send(8'hF3, 1'b0);
      chk_state("R7", 1'b1, 1'b1, 1'b1);
      send(8'hF1, 1'b0);
      chk_state("R7", 1'b0, 1'b0, 1'b0);
      cfg_write(4, 8'h71);
      expect_store(8'hF3);
      send(8'hF3, 1'b0);
      check(tx_hold == 1'b0, "R7", "8-bit no match", int'(tx_hold), 0);

      // R9: errored stop code is stored
      expect_store(8'h13);
      send(8'h13, 1'b1);
      chk_state("R9", 1'b0, 1'b0, 1'b0);

      // R5: pair mode
      cfg_write(4, 8'h73);
      send(8'h13, 1'b0);
      check(tx_hold == 1'b0, "R5", "half pair", int'(tx_hold), 0);
      send(8'h33, 1'b0);
      chk_state("R5", 1'b1, 1'b1, 1'b1);
      send(8'h11, 1'b0);
      send(8'h22, 1'b0);
      chk_state("R5", 1'b0, 1'b0, 1'b0);

      // R6: broken sequences
      expect_store(8'h13); expect_store(8'h55);
      send(8'h13, 1'b0);
      send(8'h55, 1'b0);
      check(exp_q.size() == 0, "R6", "release order drained", exp_q.size(), 0);
      expect_store(8'h11);
      send(8'h11, 1'b0);
      send(8'h13, 1'b0);
      send(8'h33, 1'b0);
      chk_state("R6", 1'b1, 1'b1, 1'b1);

      // R8: any-character resume
      cfg_write(4, 8'h77);
      expect_store(8'h5A);
      send(8'h5A, 1'b0);
      chk_state("R8", 1'b0, 1'b0, 1'b0);
      send(8'h13, 1'b0);
      send(8'h33, 1'b0);
      check(tx_hold == 1'b1, "R8", "stop still works", int'(tx_hold), 1);
      expect_store(8'h77);
      send(8'h77, 1'b1);
      check(tx_hold == 1'b1, "R9", "errored char no resume", int'(tx_hold), 1);
      expect_store(8'h66);
      send(8'h66, 1'b0);
      check(tx_hold == 1'b0, "R8", "resume on any", int'(tx_hold), 0);

      // R10: marker mode
      cfg_write(4, 8'h78);
      expect_store(8'h33);
      send(8'h33, 1'b0);
      chk_state("R10", 1'b0, 1'b1, 1'b1);
      pulse_clr();
      expect_store(8'h13);
      send(8'h13, 1'b0);
      chk_state("R10", 1'b0, 1'b0, 1'b0);

      // R12: pass-through
      cfg_write(4, 8'h60);
      expect_store(8'h13);
      send(8'h13, 1'b0);
      chk_state("R12", 1'b0, 1'b0, 1'b0);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6/R12", "all expected writes seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule